// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler Tap

This block is a supervisory timer that must be fed periodically by software. A free-running system prescaler drives it. Each rising edge of the prescaler's top bit advances a small watchdog counter. When that counter wraps from all ones back to zero, the block raises a one-cycle internal reset request. In the same cycle it pulses a strobe that sets the watchdog cause bit in the chip's reset status register.

Software feeds the timer by writing to one fixed bus address. The data value does not matter, and the data bus is not an input of the block. A feed clears the watchdog counter. It also clears a middle slice of the prescaler, so the next tick arrives at a time set by the feed and not by a fixed division. The low prescaler bits below the slice keep counting.

The only way to turn the timer off is a high-voltage test condition that depends on the operating mode. Monitor mode together with a high-voltage flag on either the reset or the interrupt input stops it. A break state together with a high-voltage flag on the reset input also stops it. Software has no way to disable it.

Top module: `wdog_top`

## Requirements
- R1: When rst_n is low, wd_rst_req and wd_flag_set are 0, and the prescaler and watchdog counter clear to zero. With no feed, the first request after reset release therefore follows rising clock edge number 2^(PRESC_W-1) + (2^WD_W - 1)·2^PRESC_W, counting the first edge with rst_n high as edge 1.
- R2: A cycle with bus_wr=1 and bus_addr equal to SVC_ADDR (default 16'hFFFF) feeds the timer. A write to any other address, or a cycle with bus_wr=0, has no effect on the timeout.
- R3: A feed clears the watchdog counter and the prescaler bits PRESC_W-1 down to CLR_LO. The prescaler bits below CLR_LO take their normal incremented value.
- R4: The watchdog counter advances by one only in a cycle where the prescaler's top bit changes from 0 to 1.
- R5: When the counter is all ones and advances, it wraps to zero. wd_rst_req and wd_flag_set are then both 1 for exactly one cycle, one clock edge after that transition.
- R6: While mon_mode=1 and either hv_rst=1 or hv_irq=1, the watchdog counter is held at zero and no request is raised.
- R7: While brk_state=1 and hv_rst=1, the counter is held at zero and no request is raised. brk_state=1 with only hv_irq=1 does not disable the timer.
- R8: hv_rst or hv_irq without monitor mode or break, or either mode without a high-voltage flag, does not disable the timer.
- R9: Without feeds, successive requests are exactly 2^(PRESC_W+WD_W) clock edges apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| mon_mode | input | 1 | Monitor mode active |
| brk_state | input | 1 | Break state active |
| hv_rst | input | 1 | High test voltage present on the reset input |
| hv_irq | input | 1 | High test voltage present on the interrupt input |
| wd_rst_req | output | 1 | One-cycle internal reset request on watchdog overflow |
| wd_flag_set | output | 1 | One-cycle strobe that sets the watchdog cause status bit |

## Verification
The timeout is first measured free-running from reset. This pins down the half-period of the first tick, the full tick period and the wrap count. The timer is then fed at a known prescaler phase, and the measured delay shows that the slice is cleared while the low bits carry on. Writes to a nearby address, and address matches without a strobe, must still time out; only a real feed must prevent it. Each of the six combinations of mode and high-voltage flag is held in turn, which separates the monitor and break disable paths from the ones that must leave the timer running. A behavioural model is compared on every clock throughout.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned DEF_ADDR_W  = 16;
    localparam int unsigned DEF_PRESC_W = 13;
    localparam int unsigned DEF_CLR_LO  = 5;
    localparam int unsigned DEF_WD_W    = 6;

    // Why the timer is (or is not) allowed to run this cycle
    typedef enum logic [1:0] {
        GATE_ARMED   = 2'd0,
        GATE_MON_OFF = 2'd1,
        GATE_BRK_OFF = 2'd2
    } gate_e;
endpackage

// File: rtl/wdog_presc.sv
module wdog_presc #(
    parameter int unsigned PRESC_W = wdog_pkg::DEF_PRESC_W,
    parameter int unsigned CLR_LO  = wdog_pkg::DEF_CLR_LO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_slice,
    output logic [PRESC_W-1:0] presc,
    output logic               tick
);
    localparam int unsigned TOP = PRESC_W - 1;

    typedef struct packed {
        logic [PRESC_W-1:0] cnt;
    } presc_st_t;

    presc_st_t s_d, s_q;
    logic [PRESC_W-1:0] slice_mask;

    // Bits from CLR_LO up to the top are cleared by a feed
    for (genvar b = 0; b < PRESC_W; b++) begin : g_mask
        assign slice_mask[b] = (b >= CLR_LO);
    end

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + 1'b1;
        if (clr_slice) begin
            s_d.cnt = s_d.cnt & ~slice_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign presc = s_q.cnt;
    assign tick  = ~s_q.cnt[TOP] & s_d.cnt[TOP];
endmodule

// File: rtl/wdog_gate.sv
module wdog_gate
    import wdog_pkg::*;
(
    input  logic  mon_mode,
    input  logic  brk_state,
    input  logic  hv_rst,
    input  logic  hv_irq,
    output gate_e gate_st
);
    always_comb begin
        gate_st = GATE_ARMED;
        if (mon_mode && (hv_rst || hv_irq)) begin
            gate_st = GATE_MON_OFF;
        end else if (brk_state && hv_rst) begin
            gate_st = GATE_BRK_OFF;
        end
    end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int unsigned WD_W = wdog_pkg::DEF_WD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            service,
    input  logic            gated,
    output logic [WD_W-1:0] cnt,
    output logic            req,
    output logic            flag
);
    typedef struct packed {
        logic [WD_W-1:0] cnt;
        logic            req;
        logic            flag;
    } wd_st_t;

    wd_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.req  = 1'b0;
        s_d.flag = 1'b0;
        if (service || gated) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (&s_q.cnt) begin
                s_d.req  = 1'b1;
                s_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt  = s_q.cnt;
    assign req  = s_q.req;
    assign flag = s_q.flag;
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int unsigned      ADDR_W   = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] SVC_ADDR = '1,
    parameter int unsigned      PRESC_W  = DEF_PRESC_W,
    parameter int unsigned      CLR_LO   = DEF_CLR_LO,
    parameter int unsigned      WD_W     = DEF_WD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              mon_mode,
    input  logic              brk_state,
    input  logic              hv_rst,
    input  logic              hv_irq,
    output logic              wd_rst_req,
    output logic              wd_flag_set
);
    logic               service;
    logic               tick;
    logic [PRESC_W-1:0] presc_q;
    logic [WD_W-1:0]    wd_cnt;
    gate_e              gate_st;

    assign service = bus_wr && (bus_addr == SVC_ADDR);

    wdog_presc #(.PRESC_W(PRESC_W), .CLR_LO(CLR_LO)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_slice (service),
        .presc     (presc_q),
        .tick      (tick)
    );

    wdog_gate u_gate (
        .mon_mode  (mon_mode),
        .brk_state (brk_state),
        .hv_rst    (hv_rst),
        .hv_irq    (hv_irq),
        .gate_st   (gate_st)
    );

    wdog_count #(.WD_W(WD_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .service (service),
        .gated   (gate_st != GATE_ARMED),
        .cnt     (wd_cnt),
        .req     (wd_rst_req),
        .flag    (wd_flag_set)
    );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
    parameter int unsigned       ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SVC_ADDR = '1,
    parameter int unsigned       PRESC_W  = 13,
    parameter int unsigned       CLR_LO   = 5,
    parameter int unsigned       WD_W     = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               mon_mode,
    input logic               brk_state,
    input logic               hv_rst,
    input logic               hv_irq,
    input logic               wd_rst_req,
    input logic               wd_flag_set,
    input logic [PRESC_W-1:0] presc_q,
    input logic [WD_W-1:0]    wd_cnt
);
    localparam int unsigned TOP = PRESC_W - 1;

    logic fed;
    logic mon_off;
    logic brk_off;
    assign fed     = bus_wr && (bus_addr == SVC_ADDR);
    assign mon_off = mon_mode && (hv_rst || hv_irq);
    assign brk_off = brk_state && hv_rst;

    always_comb begin
        if (rst_n) begin
            assert_flag_matches_req_R5: assert (wd_rst_req == wd_flag_set);
        end
    end

    assert_req_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |=> !wd_rst_req);

    assert_feed_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fed |=> (presc_q[TOP:CLR_LO] == '0) && (wd_cnt == '0));

    assert_feed_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fed |=> !wd_rst_req);

    assert_req_on_top_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |-> (presc_q[TOP] && !$past(presc_q[TOP])));

    assert_mon_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mon_off |=> (wd_cnt == '0) && !wd_rst_req);

    assert_brk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_off |=> (wd_cnt == '0) && !wd_rst_req);
endmodule

bind wdog_top wdog_checker #(
    .ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR), .PRESC_W(PRESC_W),
    .CLR_LO(CLR_LO), .WD_W(WD_W)
) u_wdog_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .mon_mode    (mon_mode),
    .brk_state   (brk_state),
    .hv_rst      (hv_rst),
    .hv_irq      (hv_irq),
    .wd_rst_req  (wd_rst_req),
    .wd_flag_set (wd_flag_set),
    .presc_q     (presc_q),
    .wd_cnt      (wd_cnt)
);

// File: tb/test_wdog_top.sv
module test_wdog_top;
    localparam int PW   = 8;
    localparam int LO   = 3;
    localparam int WW   = 3;
    localparam int PMOD = 1 << PW;
    localparam int HALF = 1 << (PW - 1);
    localparam int WMAX = (1 << WW) - 1;
    localparam int FIRST = HALF + WMAX * PMOD;   // 1920
    localparam int PERIOD = PMOD << WW;          // 2048

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        mon_mode = 1'b0, brk_state = 1'b0, hv_rst = 1'b0, hv_irq = 1'b0;
    logic        wd_rst_req, wd_flag_set;

    int checks = 0;
    int errors = 0;
    int edge_no = 0;
    int m_presc = 0;
    int m_wd = 0;
    bit m_req = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdog_top #(.ADDR_W(16), .SVC_ADDR(16'hFFFF), .PRESC_W(PW), .CLR_LO(LO), .WD_W(WW)) i_wdog_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .mon_mode(mon_mode), .brk_state(brk_state), .hv_rst(hv_rst), .hv_irq(hv_irq),
        .wd_rst_req(wd_rst_req), .wd_flag_set(wd_flag_set)
    );

    // Behavioural reference: integer prescaler and watchdog count
    always @(posedge clk) begin
        if (!rst_n) begin
            edge_no = 0; m_presc = 0; m_wd = 0; m_req = 1'b0;
        end else begin
            bit fed, off, tk;
            int np;
            edge_no = edge_no + 1;
            fed = bus_wr && (bus_addr == 16'hFFFF);
            off = (mon_mode && (hv_rst || hv_irq)) || (brk_state && hv_rst);
            np = (m_presc + 1) % PMOD;
            if (fed) np = np % (1 << LO);
            tk = (m_presc < HALF) && (np >= HALF);
            m_req = 1'b0;
            if (fed || off) m_wd = 0;
            else if (tk) begin
                if (m_wd == WMAX) begin m_wd = 0; m_req = 1'b1; end
                else m_wd = m_wd + 1;
            end
            m_presc = np;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst_n) begin
            chk(!wd_rst_req && !wd_flag_set, "R1 outputs low in reset",
                int'({wd_rst_req, wd_flag_set}), 0);
        end else if (!done) begin
            chk(wd_rst_req == m_req, "R4,R5 model req", int'(wd_rst_req), int'(m_req));
            chk(wd_flag_set == m_req, "R5 model flag", int'(wd_flag_set), int'(m_req));
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_wr = 1'b0; bus_addr = 16'h0000;
        mon_mode = 1'b0; brk_state = 1'b0; hv_rst = 1'b0; hv_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Edges from 'mark' until a request shows, -1 if none within 'lim'
    task automatic wait_req(input int mark, input int lim, output int n);
        n = -1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (wd_rst_req) begin n = edge_no - mark; break; end
        end
    endtask

    task automatic watch(input int cyc, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (wd_rst_req) seen = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, mark;
        bit seen;

        // R1, R4, R5, R9: free-running timeout
        do_reset();
        wait_req(0, 5000, n);
        chk(n == FIRST, "R1 first timeout edge", n, FIRST);
        mark = edge_no;
        wait_req(mark, 5000, n);
        chk(n == PERIOD, "R9 timeout period", n, PERIOD);

        // R2: near address and unstrobed address do not feed
        do_reset();
        for (int i = 0; i < 6; i++) begin
            repeat (300) @(negedge clk);
            bus_wr = 1'b1; bus_addr = 16'hFFFE;
            @(negedge clk);
            bus_wr = 1'b0; bus_addr = 16'hFFFF;
        end
        mark = 0;
        wait_req(mark, 5000, n);
        chk(n == FIRST, "R2 wrong address or no strobe ignored", n, FIRST);

        // R2: periodic feeds prevent any request
        do_reset();
        seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            bit s;
            watch(900, s);
            seen |= s;
            bus_wr = 1'b1; bus_addr = 16'hFFFF;
            @(negedge clk);
            bus_wr = 1'b0; bus_addr = 16'h0000;
        end
        chk(!seen, "R2 feeds prevent timeout", int'(seen), 0);

        // R3: feed at prescaler value 205 leaves low bits 6, next request 1914 edges later
        do_reset();
        repeat (205) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'hFFFF;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 16'h0000;
        mark = edge_no;
        wait_req(mark, 5000, n);
        chk(n == 1914, "R3 slice cleared low bits kept", n, 1914);

        // R6: monitor mode with either high-voltage flag
        do_reset();
        mon_mode = 1'b1; hv_rst = 1'b1;
        watch(3000, seen);
        chk(!seen, "R6 monitor with hv_rst disables", int'(seen), 0);
        hv_rst = 1'b0; hv_irq = 1'b1;
        watch(3000, seen);
        chk(!seen, "R6 monitor with hv_irq disables", int'(seen), 0);
        mon_mode = 1'b0; hv_irq = 1'b0;
        mark = edge_no;
        wait_req(mark, 5000, n);
        chk(n > 0 && n <= PERIOD, "R6 resumes after release", n, PERIOD);

        // R7: break with hv_rst disables, with hv_irq does not
        do_reset();
        brk_state = 1'b1; hv_rst = 1'b1;
        watch(3000, seen);
        chk(!seen, "R7 break with hv_rst disables", int'(seen), 0);
        do_reset();
        brk_state = 1'b1; hv_irq = 1'b1;
        wait_req(0, 5000, n);
        chk(n == FIRST, "R7 break with hv_irq still times out", n, FIRST);

        // R8: a flag or a mode alone does not disable
        do_reset();
        hv_rst = 1'b1; hv_irq = 1'b1;
        wait_req(0, 5000, n);
        chk(n == FIRST, "R8 hv flags alone", n, FIRST);
        do_reset();
        mon_mode = 1'b1; brk_state = 1'b1;
        wait_req(0, 5000, n);
        chk(n == FIRST, "R8 modes alone", n, FIRST);

        done = 1'b1;
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule